// File: doc/BRIEF.md
# Clock and Processor Mode Control Register

This block holds the byte that steers the clock generator and the operating mode of a small 8-bit microcontroller. Software writes it over the data bus, either as a whole byte or with a single-bit set or clear. Its fields leave the block as plain select and enable lines: the oscillator type, the processor mode, the division ratio, the run enables of the two oscillators, and the choice of clock that drives both the CPU and the watchdog count.

Three bits are critical: the oscillator type (bit 5) and the processor mode (bits 1 and 0). A runaway program must not be able to change them. After reset the first accepted write of any kind decides them once, and then they stay frozen until the next reset. A single-bit operation aimed at any other bit also uses up that one chance. The block also refuses the double-speed division code while the RC oscillator is selected.

The division field encodes 00 as double speed from XIN, 01 as XIN divided by 2, 10 as XIN divided by 8, and 11 as the on-chip oscillator.

Top module: `clkmode_reg`

## Requirements
- R1: After reset, rd_data reads 8'hC8 and lock_flag is 0. That value means: division 11, on-chip oscillator running, XIN stopped, oscillator type 0 (ceramic or external), processor mode 00.
- R2: A byte write (wr_op 00 with wr_en high) loads bits 7, 6, 4, 3 and 2 from wr_data on the next clock edge. R6 can override bits 7 and 6.
- R3: The protected bits 5, 1 and 0 take the value from the first accepted write after reset. Every later write leaves them unchanged.
- R4: A bit set (wr_op 01) or bit clear (wr_op 10) changes only the bit numbered by wr_bit. Such an operation locks the protected bits even when it targets bit 2, 3, 4, 6 or 7.
- R5: lock_flag becomes 1 on the first accepted write after reset and stays 1 until reset.
- R6: If a write would leave bit 5 at 1 (RC) together with division 00 (double speed), bits 7 and 6 keep their previous value instead. If that previous value was 00, they become 01.
- R7: wr_op 11 and cycles with wr_en low change neither the register nor lock_flag.
- R8: osc_rc shows bit 5, proc_mode shows bits 1:0, div_sel shows bits 7:6, xin_run shows bit 4 and onchip_run shows bit 3. rd_data shows the whole register.
- R9: clk_src_onchip is 1 exactly when div_sel is 11. This selects the on-chip oscillator as the clock for both the CPU and the watchdog count; otherwise XIN is used.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Bus clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Write strobe for one cycle |
| wr_op | input | 2 | 00 byte write, 01 bit set, 10 bit clear, 11 ignored |
| wr_bit | input | 3 | Target bit index for set and clear |
| wr_data | input | 8 | Byte for a byte write |
| rd_data | output | 8 | Current register contents |
| lock_flag | output | 1 | Protected bits are frozen |
| osc_rc | output | 1 | 1 selects RC oscillation, 0 ceramic or external |
| proc_mode | output | 2 | Processor mode |
| div_sel | output | 2 | Clock division ratio code |
| xin_run | output | 1 | Main XIN oscillator enable |
| onchip_run | output | 1 | On-chip oscillator enable |
| clk_src_onchip | output | 1 | CPU and watchdog clock from on-chip oscillator |

## Verification
A lock state that is wrong shows up on the cycle after the next write. Either the protected bits change when they should hold, or they hold when the first write should have set them. Both cases are visible on osc_rc, proc_mode and rd_data. A legality check that is wrong appears at once as osc_rc high together with div_sel 00. A wrong bit-operation decode shows as a change in a bit that was not targeted. The sequences start from reset with bit operations aimed at both protected and unprotected bits, so that each locking path is reached first.

// File: rtl/clkmode_pkg.sv
package clkmode_pkg;
   typedef enum logic [1:0] {
      OP_BYTE = 2'b00,
      OP_SET  = 2'b01,
      OP_CLR  = 2'b10,
      OP_NONE = 2'b11
   } cm_op_e;

   localparam logic [1:0] DIV_DOUBLE = 2'b00;
   localparam logic [1:0] DIV_HALF   = 2'b01;
   localparam logic [1:0] DIV_EIGHTH = 2'b10;
   localparam logic [1:0] DIV_ONCHIP = 2'b11;
endpackage

// File: rtl/clkmode_wrdec.sv
// Builds the candidate register value from the bus operation.
module clkmode_wrdec
   import clkmode_pkg::*;
#(
   parameter int DATA_W = 8,
   localparam int IDX_W = $clog2(DATA_W)
) (
   input  logic [DATA_W-1:0] cur,
   input  logic [1:0]        op,
   input  logic [IDX_W-1:0]  bit_idx,
   input  logic [DATA_W-1:0] data,
   output logic [DATA_W-1:0] cand,
   output logic              accept
);
   logic [DATA_W-1:0] sel_mask;

   for (genvar i = 0; i < DATA_W; i++) begin : g_sel
      assign sel_mask[i] = (bit_idx == IDX_W'(i));
   end

   always_comb begin
      cand   = cur;
      accept = 1'b1;
      case (cm_op_e'(op))
         OP_BYTE: cand = data;
         OP_SET:  cand = cur | sel_mask;
         OP_CLR:  cand = cur & ~sel_mask;
         default: accept = 1'b0;
      endcase
   end
endmodule

// File: rtl/clkmode_protect.sv
// Holds protected bits at their current value once the lock is set.
module clkmode_protect #(
   parameter int                DATA_W    = 8,
   parameter logic [DATA_W-1:0] PROT_MASK = '0
) (
   input  logic [DATA_W-1:0] cur,
   input  logic [DATA_W-1:0] cand,
   input  logic              locked,
   output logic [DATA_W-1:0] merged
);
   for (genvar i = 0; i < DATA_W; i++) begin : g_bit
      if (PROT_MASK[i]) begin : g_prot
         assign merged[i] = locked ? cur[i] : cand[i];
      end else begin : g_free
         assign merged[i] = cand[i];
      end
   end
endmodule

// File: rtl/clkmode_legal.sv
// Rejects double-speed division while RC oscillation is selected.
module clkmode_legal
   import clkmode_pkg::*;
#(
   parameter int DATA_W  = 8,
   parameter int OSC_POS = 5,
   parameter int DIV_LSB = 6
) (
   input  logic [DATA_W-1:0] cur,
   input  logic [DATA_W-1:0] merged,
   output logic [DATA_W-1:0] fixed
);
   logic [1:0] cur_div;
   logic [1:0] new_div;
   logic       illegal;

   assign cur_div = cur[DIV_LSB +: 2];
   assign new_div = merged[DIV_LSB +: 2];
   assign illegal = merged[OSC_POS] && (new_div == DIV_DOUBLE);

   always_comb begin
      fixed = merged;
      if (illegal) begin
         fixed[DIV_LSB +: 2] = (cur_div == DIV_DOUBLE) ? DIV_HALF : cur_div;
      end
   end
endmodule

// File: rtl/clkmode_reg.sv
module clkmode_reg
   import clkmode_pkg::*;
#(
   parameter int          DATA_W    = 8,
   parameter int          OSC_POS   = 5,
   parameter int          PM_LSB    = 0,
   parameter int          DIV_LSB   = 6,
   parameter int          XIN_POS   = 4,
   parameter int          ONC_POS   = 3,
   parameter logic [7:0]  RESET_VAL = 8'hC8,
   localparam int         IDX_W     = $clog2(DATA_W)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              wr_en,
   input  logic [1:0]        wr_op,
   input  logic [IDX_W-1:0]  wr_bit,
   input  logic [DATA_W-1:0] wr_data,
   output logic [DATA_W-1:0] rd_data,
   output logic              lock_flag,
   output logic              osc_rc,
   output logic [1:0]        proc_mode,
   output logic [1:0]        div_sel,
   output logic              xin_run,
   output logic              onchip_run,
   output logic              clk_src_onchip
);
   localparam logic [DATA_W-1:0] PROT_MASK =
      (DATA_W'(1) << OSC_POS) | (DATA_W'(3) << PM_LSB);

   if (DATA_W != 8) begin : g_bad_width
      $error("clkmode_reg: DATA_W must be 8");
   end
   if (DIV_LSB > DATA_W - 2 || PM_LSB > DATA_W - 2) begin : g_bad_field
      $error("clkmode_reg: two-bit field out of range");
   end
   if (RESET_VAL[OSC_POS] && RESET_VAL[DIV_LSB +: 2] == DIV_DOUBLE) begin : g_bad_reset
      $error("clkmode_reg: reset value combines RC and double speed");
   end

   logic [DATA_W-1:0] cfg_q;
   logic              lock_q;
   logic [DATA_W-1:0] cand;
   logic [DATA_W-1:0] merged;
   logic [DATA_W-1:0] fixed;
   logic              accept;

   clkmode_wrdec #(.DATA_W(DATA_W)) i_wrdec (
      .cur(cfg_q), .op(wr_op), .bit_idx(wr_bit), .data(wr_data),
      .cand(cand), .accept(accept)
   );

   clkmode_protect #(.DATA_W(DATA_W), .PROT_MASK(PROT_MASK)) i_protect (
      .cur(cfg_q), .cand(cand), .locked(lock_q), .merged(merged)
   );

   clkmode_legal #(.DATA_W(DATA_W), .OSC_POS(OSC_POS), .DIV_LSB(DIV_LSB)) i_legal (
      .cur(cfg_q), .merged(merged), .fixed(fixed)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cfg_q  <= DATA_W'(RESET_VAL);
         lock_q <= 1'b0;
      end else if (wr_en && accept) begin
         cfg_q  <= fixed;
         lock_q <= 1'b1;
      end
   end

   assign rd_data        = cfg_q;
   assign lock_flag      = lock_q;
   assign osc_rc         = cfg_q[OSC_POS];
   assign proc_mode      = cfg_q[PM_LSB +: 2];
   assign div_sel        = cfg_q[DIV_LSB +: 2];
   assign xin_run        = cfg_q[XIN_POS];
   assign onchip_run     = cfg_q[ONC_POS];
   assign clk_src_onchip = (cfg_q[DIV_LSB +: 2] == DIV_ONCHIP);
endmodule

// File: rtl/clkmode_chk.sv
module clkmode_chk (
   input logic       clk,
   input logic       rst_n,
   input logic       wr_en,
   input logic [1:0] wr_op,
   input logic [7:0] rd_data,
   input logic       lock_flag,
   input logic       osc_rc,
   input logic [1:0] proc_mode,
   input logic [1:0] div_sel
);
   // R3
   prot_frozen_chk: assert property (@(posedge clk) disable iff (!rst_n)
      lock_flag |=> $stable({osc_rc, proc_mode}));

   // R4
   bitop_locks_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_en && (wr_op == 2'b01 || wr_op == 2'b10)) |=> lock_flag);

   // R5
   lock_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
      lock_flag |=> lock_flag);

   // R6
   no_rc_double_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !(osc_rc && div_sel == 2'b00));

   // R7
   idle_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (!wr_en || wr_op == 2'b11) |=> ($stable(rd_data) && $stable(lock_flag)));
endmodule

bind clkmode_reg clkmode_chk i_clkmode_chk (
   .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_op(wr_op),
   .rd_data(rd_data), .lock_flag(lock_flag), .osc_rc(osc_rc),
   .proc_mode(proc_mode), .div_sel(div_sel)
);

// File: tb/test_clkmode_reg.sv
module test_clkmode_reg;
   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       wr_en = 1'b0;
   logic [1:0] wr_op = 2'b11;
   logic [2:0] wr_bit = '0;
   logic [7:0] wr_data = '0;
   logic [7:0] rd_data;
   logic       lock_flag, osc_rc, xin_run, onchip_run, clk_src_onchip;
   logic [1:0] proc_mode, div_sel;

   int n_checks = 0;
   int n_fail   = 0;

   always #5 clk = ~clk;

   clkmode_reg i_clkmode_reg (
      .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_op(wr_op), .wr_bit(wr_bit),
      .wr_data(wr_data), .rd_data(rd_data), .lock_flag(lock_flag),
      .osc_rc(osc_rc), .proc_mode(proc_mode), .div_sel(div_sel),
      .xin_run(xin_run), .onchip_run(onchip_run), .clk_src_onchip(clk_src_onchip)
   );

   // {op, bit, data, expected register}; lock expected 1 after each
   localparam logic [20:0] VEC [6] = '{
      {2'b01, 3'd2, 8'h00, 8'hCC},   // R4 set bit 2 locks protected group
      {2'b00, 3'd0, 8'h23, 8'h00},   // R3 R2 protected ignored, free bits load
      {2'b01, 3'd5, 8'h00, 8'h00},   // R3 set on locked bit 5 ignored
      {2'b00, 3'd0, 8'h50, 8'h50},   // R2 divide-by-2, XIN on
      {2'b10, 3'd4, 8'h00, 8'h40},   // R4 clear bit 4 only
      {2'b01, 3'd7, 8'h00, 8'hC0}    // R4 set bit 7 -> on-chip source
   };

   task automatic check_state(input logic [7:0] exp, input logic exp_lock, input string tag);
      n_checks++;
      if (rd_data !== exp || lock_flag !== exp_lock) begin
         n_fail++;
         $display("FAIL %s: rd_data=%h lock=%b expected rd_data=%h lock=%b",
                  tag, rd_data, lock_flag, exp, exp_lock);
      end
      n_checks++;
      // R8 field outputs, R9 clock source
      if (osc_rc !== exp[5] || proc_mode !== exp[1:0] || div_sel !== exp[7:6] ||
          xin_run !== exp[4] || onchip_run !== exp[3] ||
          clk_src_onchip !== (exp[7:6] == 2'b11)) begin
         n_fail++;
         $display("FAIL %s (R8/R9 fields): osc=%b pm=%b div=%b xin=%b onc=%b src=%b expected from %h",
                  tag, osc_rc, proc_mode, div_sel, xin_run, onchip_run, clk_src_onchip, exp);
      end
   endtask

   task automatic apply(input logic [1:0] op, input logic [2:0] idx, input logic [7:0] data);
      @(negedge clk);
      wr_en = 1'b1; wr_op = op; wr_bit = idx; wr_data = data;
      @(negedge clk);
      wr_en = 1'b0; wr_op = 2'b11;
   endtask

   task automatic do_reset();
      @(negedge clk);
      rst_n = 1'b0;
      repeat (2) @(negedge clk);
      rst_n = 1'b1;
   endtask

   initial begin
      do_reset();
      check_state(8'hC8, 1'b0, "R1 reset");
      for (int k = 0; k < 6; k++) begin
         apply(VEC[k][20:19], VEC[k][18:16], VEC[k][15:8]);
         check_state(VEC[k][7:0], 1'b1, $sformatf("R2/R3/R4 vector %0d", k));
      end
      repeat (3) @(negedge clk);
      check_state(8'hC0, 1'b1, "R5 R7 lock sticky, idle holds");

      // R7 reserved op ignored, no lock
      do_reset();
      apply(2'b11, 3'd0, 8'hFF);
      check_state(8'hC8, 1'b0, "R7 reserved op");

      // R3 first write sets RC, R6 double speed refused
      apply(2'b00, 3'd0, 8'h21);
      check_state(8'hE1, 1'b1, "R6 RC with double speed refused");
      apply(2'b00, 3'd0, 8'h00);
      check_state(8'hE1, 1'b1, "R3 R6 locked RC, double speed refused");
      apply(2'b00, 3'd0, 8'h80);
      check_state(8'hA1, 1'b1, "R2 divide-by-8 under RC");
      apply(2'b10, 3'd7, 8'h00);
      check_state(8'hA1, 1'b1, "R6 bit clear to double speed refused");

      // R4 bit set on protected bit is the one allowed change
      do_reset();
      apply(2'b01, 3'd5, 8'h00);
      check_state(8'hE8, 1'b1, "R4 set bit 5 before lock");
      apply(2'b01, 3'd0, 8'h00);
      check_state(8'hE8, 1'b1, "R3 set bit 0 after lock");

      // R4 clear on protected bit still consumes the lock
      do_reset();
      apply(2'b10, 3'd1, 8'h00);
      check_state(8'hC8, 1'b1, "R4 clear bit 1 locks");
      apply(2'b00, 3'd0, 8'h03);
      check_state(8'h00, 1'b1, "R3 processor mode frozen");

      // R5 reset clears the lock
      do_reset();
      check_state(8'hC8, 1'b0, "R5 reset clears lock");

      $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
      $finish;
   end

   initial begin
      repeat (100000) @(posedge clk);
      n_checks++;
      n_fail++;
      $display("FAIL watchdog: run did not complete, expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
      $finish;
   end
endmodule